// File: doc/BRIEF.md
# Shift, Rotate and Mask Unit

This block is the combinational shift and rotate datapath of an integer execution stage. In one pass it computes one of six operations on a 64-bit source operand: logical left shift, logical or arithmetic right shift, sign-extend-then-shift-left, rotate-and-insert under a mask, and rotate with only the left or only the right side of a mask applied. A 32-bit mode flag selects word behaviour, which changes the shift-amount width and either zeroes or sign-fills the upper half of the result.

Masks come from a begin index and an end index. Indices count from the most significant bit, so index 0 is bit 63 and index 63 is bit 0. When the begin index is greater than the end index, the mask wraps around. The rotate-and-insert form merges the rotated value with an insertion operand under that mask. The opcode context and tag pass straight through, so a scheduler can pair each result with its request. A result-valid flag reports whether a real operation took place. No cycle of latency is added.

Top module: `srmUnit`

## Requirements
- R1: Opcode 1 (shift left) in 64-bit mode shifts the source left by the 7-bit amount. An amount of 64 to 127 gives zero.
- R2: Opcode 1 in 32-bit mode shifts by the low 6 bits of the amount and keeps the low 32 bits of the shifted value. Bits 63:32 of the result are zero.
- R3: Opcode 2 (shift right) with the signed flag clear is a logical shift. In 64-bit mode it shifts the whole operand by the 7-bit amount. In 32-bit mode it shifts only the low word by the low 6 bits of the amount and zeroes bits 63:32.
- R4: Opcode 2 with the signed flag set in 32-bit mode shifts the low word arithmetically by the low 6 bits of the amount. Every bit of 63:32 equals source bit 31.
- R5: Opcode 2 with the signed flag set in 64-bit mode shifts the whole operand arithmetically by the 7-bit amount. Amounts of 64 or more give 64 copies of bit 63.
- R6: Opcode 3 in 64-bit mode sign-extends source bits 31:0 to 64 bits, then shifts left by the 7-bit amount. In 32-bit mode it gives the same result as R2.
- R7: For the rotate opcodes 4, 5 and 6, 64-bit mode rotates the source left by amount bits 5:0. 32-bit mode rotates the low word left by amount bits 4:0, and the rotated word appears in both halves before masking.
- R8: The mask uses most-significant-first index order. The begin part covers indices from the begin index to 63. The end part covers indices from 0 to the end index. Opcode 4 uses their AND when begin is not greater than end, and their OR otherwise.
- R9: Opcode 4 returns (rotated AND mask) OR (insertion operand AND NOT mask).
- R10: Opcode 5 returns the rotated value ANDed with the begin part alone. Opcode 6 returns the rotated value ANDed with the end part alone. The insertion operand has no effect on either.
- R11: The context and tag outputs always equal the context and tag inputs.
- R12: The result-valid flag is 1 for opcodes 1 to 6. Opcodes 0 and 7 give a zero result with the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcOp | input | 64 | Operand to shift or rotate |
| amtIn | input | 7 | Shift or rotate amount |
| insOp | input | 64 | Insertion operand for rotate-and-insert |
| opSel | input | 3 | Opcode: 0 none, 1 shl, 2 shr, 3 sext-shl, 4 rotate-insert, 5 rotate clear-left, 6 rotate clear-right, 7 none |
| wordMode | input | 1 | 1 selects 32-bit behaviour |
| signedOp | input | 1 | 1 selects an arithmetic right shift |
| mbIdx | input | 6 | Mask begin index, most-significant-first |
| meIdx | input | 6 | Mask end index, most-significant-first |
| ctxIn | input | 8 | Operation context |
| tagIn | input | 4 | Request tag |
| result | output | 64 | Result |
| resultValid | output | 1 | An operation was performed |
| ctxOut | output | 8 | Context, passed through |
| tagOut | output | 4 | Tag, passed through |

## Verification
In the rotate-and-insert form, mask wrap-around and the 32-bit word rotation apply to the same vector: the rotated word must land in both halves and then pass through a mask that is either an AND or an OR of the two parts. The bench provokes this by sweeping every begin/end index pair, and sweeping rotate amounts in both modes against one wrapping mask and one non-wrapping mask. In the same sweep, 32-bit sign fill meets amounts of 32 and above, where the low word itself becomes all copies of the sign. Each vector is judged against a bit-by-bit model of rotation and mask membership written in the bench.

// File: rtl/srmPkg.sv
package srmPkg;
  typedef enum logic [2:0] {
    OP_NONE    = 3'd0,
    OP_SHL     = 3'd1,
    OP_SHR     = 3'd2,
    OP_EXTSL   = 3'd3,
    OP_ROTINS  = 3'd4,
    OP_ROTCLRL = 3'd5,
    OP_ROTCLRR = 3'd6,
    OP_RSVD    = 3'd7
  } srmOp_e;

  // Strobes from control to datapath and mask generator
  typedef struct packed {
    logic doShl;
    logic doShr;
    logic doRot;
    logic arith;
    logic word;
    logic sext;
    logic useBegin;
    logic useEnd;
    logic insert;
    logic valid;
  } srmStrobes_t;
endpackage

// File: rtl/srmControl.sv
module srmControl
  import srmPkg::*;
(
  input  logic [2:0]  opSel,
  input  logic        wordMode,
  input  logic        signedOp,
  output srmStrobes_t st
);
  srmOp_e op;
  assign op = srmOp_e'(opSel);

  always_comb begin
    st = '0;
    case (op)
      OP_SHL:     st.doShl = 1'b1;
      OP_EXTSL: begin
        st.doShl = 1'b1;
        st.sext  = 1'b1;
      end
      OP_SHR: begin
        st.doShr = 1'b1;
        st.arith = signedOp;
      end
      OP_ROTINS: begin
        st.doRot    = 1'b1;
        st.useBegin = 1'b1;
        st.useEnd   = 1'b1;
        st.insert   = 1'b1;
      end
      OP_ROTCLRL: begin
        st.doRot    = 1'b1;
        st.useBegin = 1'b1;
      end
      OP_ROTCLRR: begin
        st.doRot  = 1'b1;
        st.useEnd = 1'b1;
      end
      default: ;
    endcase
    st.valid = st.doShl | st.doShr | st.doRot;
    st.word  = st.valid & wordMode;
  end

  always_comb begin
    a_r12_one_unit: assert ($onehot0({st.doShl, st.doShr, st.doRot}))
      else $error("R12: more than one unit selected");
    if (st.insert) begin
      a_r9_insert_full_mask: assert (st.useBegin && st.useEnd && st.doRot)
        else $error("R9: insert without a two-sided mask");
    end
    if (st.doRot) begin
      a_r10_rot_has_mask: assert (st.useBegin || st.useEnd)
        else $error("R10: rotate without a mask part");
    end
  end
endmodule

// File: rtl/srmMaskGen.sv
module srmMaskGen
  import srmPkg::*;
#(
  parameter int W = 64,
  localparam int IDX_W = $clog2(W)
) (
  input  srmStrobes_t      st,
  input  logic [IDX_W-1:0] mbIdx,
  input  logic [IDX_W-1:0] meIdx,
  output logic [W-1:0]     mask
);
  logic [W-1:0] beginPart;
  logic [W-1:0] endPart;
  logic         wraps;

  // MSB-first index k maps to bit W-1-k
  assign beginPart = {W{1'b1}} >> mbIdx;
  assign endPart   = {W{1'b1}} << (~meIdx);
  assign wraps     = mbIdx > meIdx;

  always_comb begin
    if (st.useBegin && st.useEnd)
      mask = wraps ? (beginPart | endPart) : (beginPart & endPart);
    else if (st.useBegin)
      mask = beginPart;
    else if (st.useEnd)
      mask = endPart;
    else
      mask = {W{1'b1}};
  end

  always_comb begin
    if (st.useBegin && st.useEnd && !wraps) begin
      a_r8_span_count: assert ($countones(mask) == int'(meIdx) - int'(mbIdx) + 1)
        else $error("R8: contiguous mask has wrong width");
    end
    if (st.useBegin && st.useEnd && wraps) begin
      a_r8_wrap_count: assert ($countones(mask) == W - (int'(mbIdx) - int'(meIdx) - 1))
        else $error("R8: wrapped mask has wrong width");
    end
  end
endmodule

// File: rtl/srmDatapath.sv
module srmDatapath
  import srmPkg::*;
#(
  parameter int W = 64,
  localparam int IDX_W = $clog2(W),
  localparam int HALF = W / 2
) (
  input  srmStrobes_t    st,
  input  logic [W-1:0]   srcOp,
  input  logic [IDX_W:0] amtIn,
  input  logic [W-1:0]   insOp,
  input  logic [W-1:0]   mask,
  output logic [W-1:0]   result
);
  logic [IDX_W-1:0] amtShort;
  logic [HALF-1:0]  lowWord;
  logic [W-1:0]     leftSrc;
  logic [W-1:0]     shlWide;
  logic [W-1:0]     shlRes;
  logic [HALF-1:0]  shrLow;
  logic [W-1:0]     shrRes;
  logic [W-1:0]     rotSrc;
  logic [IDX_W-1:0] rotAmt;
  logic [IDX_W:0]   backAmt;
  logic [W-1:0]     rotated;
  logic [W-1:0]     rotRes;

  assign amtShort = amtIn[IDX_W-1:0];
  assign lowWord  = srcOp[HALF-1:0];

  // Left shifts, plain or with word sign extension
  assign leftSrc = st.sext ? {{HALF{lowWord[HALF-1]}}, lowWord} : srcOp;
  assign shlWide = srcOp << amtShort;
  assign shlRes  = st.word ? {{HALF{1'b0}}, shlWide[HALF-1:0]} : (leftSrc << amtIn);

  // Right shifts
  assign shrLow = st.arith ? $unsigned($signed(lowWord) >>> amtShort) : (lowWord >> amtShort);
  always_comb begin
    if (st.word)
      shrRes = {{HALF{st.arith & lowWord[HALF-1]}}, shrLow};
    else if (st.arith)
      shrRes = $unsigned($signed(srcOp) >>> amtIn);
    else
      shrRes = srcOp >> amtIn;
  end

  // Rotate; a word rotation runs on the duplicated low word
  assign rotSrc  = st.word ? {lowWord, lowWord} : srcOp;
  assign rotAmt  = st.word ? {1'b0, amtIn[IDX_W-2:0]} : amtShort;
  assign backAmt = (IDX_W+1)'(W) - {1'b0, rotAmt};
  assign rotated = (rotSrc << rotAmt) | (rotSrc >> backAmt);
  assign rotRes  = (rotated & mask) | ((st.insert ? insOp : {W{1'b0}}) & ~mask);

  always_comb begin
    if (st.doShl)      result = shlRes;
    else if (st.doShr) result = shrRes;
    else if (st.doRot) result = rotRes;
    else               result = {W{1'b0}};
  end

  always_comb begin
    if (st.doShl && st.word) begin
      a_r2_upper_zero: assert (result[W-1:HALF] == '0)
        else $error("R2: word left shift left upper bits set");
    end
    if (st.doShr && st.word && !st.arith) begin
      a_r3_upper_zero: assert (result[W-1:HALF] == '0)
        else $error("R3: word logical shift left upper bits set");
    end
    if (st.doShr && st.word && st.arith) begin
      a_r4_sign_fill: assert (result[W-1:HALF] == {HALF{srcOp[HALF-1]}})
        else $error("R4: word arithmetic shift upper bits not sign");
    end
    if (!st.valid) begin
      a_r12_idle_zero: assert (result == '0)
        else $error("R12: idle opcode produced a result");
    end
  end
endmodule

// File: rtl/srmUnit.sv
module srmUnit
  import srmPkg::*;
#(
  parameter int W = 64,
  parameter int CTX_W = 8,
  parameter int TAG_W = 4,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     srcOp,
  input  logic [IDX_W:0]   amtIn,
  input  logic [W-1:0]     insOp,
  input  logic [2:0]       opSel,
  input  logic             wordMode,
  input  logic             signedOp,
  input  logic [IDX_W-1:0] mbIdx,
  input  logic [IDX_W-1:0] meIdx,
  input  logic [CTX_W-1:0] ctxIn,
  input  logic [TAG_W-1:0] tagIn,
  output logic [W-1:0]     result,
  output logic             resultValid,
  output logic [CTX_W-1:0] ctxOut,
  output logic [TAG_W-1:0] tagOut
);
  srmStrobes_t  st;
  logic [W-1:0] mask;

  srmControl i_ctrl (
    .opSel    (opSel),
    .wordMode (wordMode),
    .signedOp (signedOp),
    .st       (st)
  );

  srmMaskGen #(.W(W)) i_mask (
    .st    (st),
    .mbIdx (mbIdx),
    .meIdx (meIdx),
    .mask  (mask)
  );

  srmDatapath #(.W(W)) i_dp (
    .st     (st),
    .srcOp  (srcOp),
    .amtIn  (amtIn),
    .insOp  (insOp),
    .mask   (mask),
    .result (result)
  );

  assign resultValid = st.valid;
  assign ctxOut      = ctxIn;
  assign tagOut      = tagIn;

  always_comb begin
    if (resultValid) begin
      a_r12_valid_op: assert (opSel != 3'd0 && opSel != 3'd7)
        else $error("R12: valid raised for a reserved opcode");
    end
  end
endmodule

// File: tb/test_srmUnit.sv
module test_srmUnit;
  localparam int W = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] srcOp, insOp, result;
  logic [6:0]  amtIn;
  logic [2:0]  opSel;
  logic        wordMode, signedOp, resultValid;
  logic [5:0]  mbIdx, meIdx;
  logic [7:0]  ctxIn, ctxOut;
  logic [3:0]  tagIn, tagOut;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  srmUnit i_srmUnit (
    .srcOp(srcOp), .amtIn(amtIn), .insOp(insOp), .opSel(opSel),
    .wordMode(wordMode), .signedOp(signedOp), .mbIdx(mbIdx), .meIdx(meIdx),
    .ctxIn(ctxIn), .tagIn(tagIn), .result(result), .resultValid(resultValid),
    .ctxOut(ctxOut), .tagOut(tagOut)
  );

  function automatic logic [63:0] modelMask(int op, int mb, int me);
    logic [63:0] m;
    for (int j = 0; j < 64; j++) begin
      int k = 63 - j;
      bit inB = (k >= mb);
      bit inE = (k <= me);
      if (op == 5)       m[j] = inB;
      else if (op == 6)  m[j] = inE;
      else if (mb <= me) m[j] = inB && inE;
      else               m[j] = inB || inE;
    end
    return m;
  endfunction

  function automatic logic [64:0] model(int op, bit wd, bit sg, logic [63:0] s,
                                        int amt, logic [63:0] ins, int mb, int me);
    logic [63:0] o = '0;
    logic [63:0] x;
    logic [63:0] rot;
    logic [63:0] m;
    int a;
    case (op)
      1, 3: begin
        if (wd) begin
          a = amt % 64;
          for (int i = 0; i < 32; i++) o[i] = (i >= a) ? s[i-a] : 1'b0;
        end else begin
          x = (op == 3) ? {{32{s[31]}}, s[31:0]} : s;
          for (int i = 0; i < 64; i++) o[i] = (i >= amt) ? x[i-amt] : 1'b0;
        end
      end
      2: begin
        if (wd) begin
          a = amt % 64;
          for (int i = 0; i < 32; i++) o[i] = (i + a < 32) ? s[i+a] : (sg & s[31]);
          for (int i = 32; i < 64; i++) o[i] = sg & s[31];
        end else begin
          for (int i = 0; i < 64; i++) o[i] = (i + amt < 64) ? s[i+amt] : (sg & s[63]);
        end
      end
      4, 5, 6: begin
        x = wd ? {s[31:0], s[31:0]} : s;
        a = wd ? (amt % 32) : (amt % 64);
        for (int i = 0; i < 64; i++) rot[i] = x[(i - a + 64) % 64];
        m = modelMask(op, mb, me);
        o = (op == 4) ? ((rot & m) | (ins & ~m)) : (rot & m);
      end
      default: o = '0;
    endcase
    return {(op >= 1 && op <= 6), o};
  endfunction

  task automatic apply(string req, int op, bit wd, bit sg, logic [63:0] s,
                       int amt, logic [63:0] ins, int mb, int me);
    logic [64:0] exp;
    @(posedge clk);
    #1;
    opSel = 3'(op); wordMode = wd; signedOp = sg; srcOp = s; amtIn = 7'(amt);
    insOp = ins; mbIdx = 6'(mb); meIdx = 6'(me);
    ctxIn = ctxIn + 8'd37; tagIn = tagIn + 4'd3;
    exp = model(op, wd, sg, s, amt, ins, mb, me);
    @(negedge clk);
    checks++;
    if ({resultValid, result} !== exp) begin
      errors++;
      $display("FAIL %s op=%0d word=%0b sgn=%0b amt=%0d mb=%0d me=%0d actual=%0b_%h expected=%0b_%h",
               req, op, wd, sg, amt, mb, me, resultValid, result, exp[64], exp[63:0]);
    end
    checks++;
    if (ctxOut !== ctxIn || tagOut !== tagIn) begin
      errors++;
      $display("FAIL R11 actual=%h/%h expected=%h/%h", ctxOut, tagOut, ctxIn, tagIn);
    end
  endtask

  function automatic string shiftReq(int op, bit wd, bit sg);
    if (op == 1) return wd ? "R2" : "R1";
    if (op == 3) return "R6";
    if (!sg) return "R3";
    return wd ? "R4" : "R5";
  endfunction

  logic [63:0] pats [4];

  initial begin
    pats[0] = 64'h8123_4567_89AB_CDEF;
    pats[1] = 64'h7FED_CBA9_F654_3210;
    pats[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[3] = 64'h0000_0000_0000_0001;
    ctxIn = 8'h11; tagIn = 4'h2;
    opSel = '0; wordMode = 0; signedOp = 0; srcOp = '0; amtIn = '0;
    insOp = '0; mbIdx = '0; meIdx = '0;

    // R12: idle state and reserved opcodes
    apply("R12", 0, 0, 0, 64'h0, 0, 64'h0, 0, 0);
    apply("R12", 0, 1, 1, pats[0], 9, pats[1], 3, 60);
    apply("R12", 7, 0, 1, pats[2], 17, pats[2], 50, 10);
    apply("R12", 7, 1, 0, pats[1], 127, pats[0], 0, 63);

    // R1..R6: shifts across every amount, both modes, both signs
    foreach (pats[p]) begin
      for (int op = 1; op <= 3; op++) begin
        for (int wd = 0; wd < 2; wd++) begin
          for (int sg = 0; sg < 2; sg++) begin
            for (int amt = 0; amt < 128; amt++) begin
              apply(shiftReq(op, wd[0], sg[0]), op, wd[0], sg[0], pats[p], amt, pats[(p+1)%4], 7, 44);
            end
          end
        end
      end
    end

    // R7: rotate amounts in both modes with one contiguous and one wrapping mask
    for (int op = 4; op <= 6; op++) begin
      for (int wd = 0; wd < 2; wd++) begin
        for (int amt = 0; amt < 128; amt += 3) begin
          apply("R7", op, wd[0], 0, pats[0], amt, pats[1], 5, 40);
          apply("R7", op, wd[0], 1, pats[1], amt, pats[0], 50, 10);
        end
      end
    end

    // R8 / R9: every begin/end pair for rotate-and-insert
    for (int mb = 0; mb < 64; mb++) begin
      for (int me = 0; me < 64; me++) begin
        apply((mb % 2 == 0) ? "R8" : "R9", 4, (me % 3 == 0), 0, pats[0], 13, pats[1], mb, me);
      end
    end

    // R10: one-sided masks; insertion operand must have no effect
    for (int i = 0; i < 64; i++) begin
      apply("R10", 5, 0, 0, pats[1], 29, 64'hFFFF_FFFF_FFFF_FFFF, i, 0);
      apply("R10", 6, 0, 0, pats[1], 29, 64'hFFFF_FFFF_FFFF_FFFF, 63, i);
      apply("R10", 5, 1, 0, pats[0], 7, 64'h5A5A_5A5A_5A5A_5A5A, i, 63 - i);
      apply("R10", 6, 1, 0, pats[0], 7, 64'h5A5A_5A5A_5A5A_5A5A, 63 - i, i);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule